// File: doc/BRIEF.md
# Pulse-Position Channel Token Decoder

This block turns a serial pulse-position frame into one output pulse per channel. A single token moves along a short shift register, and each stage of the register drives one channel output. The frame-start level (the channel-1 window) feeds the register's serial input. Each rising edge of the reconstructed pulse stream, after a small programmed lag, shifts the register by one stage. The lag makes sure the frame-start window is already high when the first shift of a frame happens. At every later shift in the frame the window is low. So exactly one token enters per frame, and each output is high for exactly one channel slot.

Both inputs are asynchronous to the system clock, so each first passes through a two-flop synchronizer. Rising edges of the pulse stream are found against a registered copy of its previous value. If no shift happens for a programmable number of clock cycles, the register is cleared. A token left over from a broken frame therefore cannot remain on an output.

Top module: `ppm_token_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register stage is cleared, so `ch_out` reads all zeros on the next cycle. This holds in the middle of a frame as well.
- R2: Each input passes through two synchronizing flops. After a rising edge of `pulse_in`, the register shifts on the (LAG_CYC+3)th rising clock edge. The count starts with the first clock edge that samples the new level.
- R3: The serial data input is the synchronized `frame_start_in` level at the moment of the shift. A one is loaded when that level is high, and a zero is loaded when it is low. If the window is held high across two pulse edges, two adjacent ones are loaded.
- R4: `ch_out[k]` shows register stage k, where bit 0 is channel 1. Each shift moves every stage's content to the next higher index. Content in the highest stage is dropped.
- R5: Suppose a frame has its frame-start window high only around its first pulse edge. Then after the k-th pulse edge of that frame, `ch_out` is one-hot with bit k-1 set, for k = 1 to NUM_CH. After any later edge, `ch_out` is all zeros.
- R6: The register changes only on a shift. A change of `frame_start_in` without a pulse edge, a long high level on `pulse_in`, or a falling edge of `pulse_in` leaves `ch_out` unchanged.
- R7: Suppose GAP_CYC consecutive clock cycles pass without a shift. Then the register is cleared at the end of the GAP_CYC-th such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| frame_start_in | input | 1 | Asynchronous frame-start (channel-1 window) level |
| pulse_in | input | 1 | Asynchronous reconstructed pulse stream |
| ch_out | output | NUM_CH | Per-channel slot outputs, bit 0 = channel 1 |

## Verification
The hardest condition to reach is the timeout. The register must clear on exactly the GAP_CYC-th idle cycle after the last shift, and not one cycle sooner. The bench loads a single token and stays idle with no edges. It then samples `ch_out` on the cycles just before and just after the computed clearing cycle. That cycle is derived from the synchronizer depth, the lag counter and the timeout. A second hard case is a frame-start window stretched over two pulse edges: the bench holds the window high across a whole slot to load two tokens.

// File: rtl/ppm_token_decoder.sv
module ppm_token_decoder #(
  parameter int NUM_CH  = 6,
  parameter int LAG_CYC = 500,
  parameter int GAP_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_in,
  input  logic              pulse_in,
  output logic [NUM_CH-1:0] ch_out
);
  localparam int LW = $clog2(LAG_CYC + 1);
  localparam int GW = $clog2(GAP_CYC);

  logic [1:0]        fs_sync, pl_sync;
  logic              pl_prev;
  logic [LW-1:0]     lag_cnt;
  logic [GW-1:0]     gap_cnt;
  logic [NUM_CH-1:0] sr;
  logic              rise, strobe, gap_hit;

  assign rise    = pl_sync[1] & ~pl_prev;
  assign strobe  = (lag_cnt == LW'(1));
  assign gap_hit = !strobe && (gap_cnt == GW'(GAP_CYC - 1));
  assign ch_out  = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_sync <= '0;
      pl_sync <= '0;
      pl_prev <= 1'b0;
      lag_cnt <= '0;
      gap_cnt <= '0;
      sr      <= '0;
    end else begin
      fs_sync <= {fs_sync[0], frame_start_in};
      pl_sync <= {pl_sync[0], pulse_in};
      pl_prev <= pl_sync[1];

      if (rise)                lag_cnt <= LW'(LAG_CYC);
      else if (lag_cnt != '0)  lag_cnt <= lag_cnt - LW'(1);

      if (strobe)              gap_cnt <= '0;
      else if (!gap_hit)       gap_cnt <= gap_cnt + GW'(1);

      if (strobe)              sr <= {sr[NUM_CH-2:0], fs_sync[1]};
      else if (gap_hit)        sr <= '0;
    end
  end
endmodule

// File: rtl/ppm_token_decoder_chk.sv
module ppm_token_decoder_chk #(
  parameter int NUM_CH  = 6,
  parameter int GAP_CYC = 250000
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              fs_q,
  input logic [NUM_CH-1:0] sr,
  input logic [NUM_CH-1:0] ch_out
);
  localparam int CW = $clog2(GAP_CYC + 1);
  logic [CW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst || strobe)               idle <= '0;
    else if (idle != CW'(GAP_CYC))   idle <= idle + CW'(1);
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> ch_out == '0);

  assert_token_source_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> sr[0] == $past(fs_q));

  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |=> ch_out[NUM_CH-1:1] == $past(sr[NUM_CH-2:0]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!strobe && idle != CW'(GAP_CYC - 1)) |=> $stable(ch_out));

  assert_timeout_R7: assert property (@(posedge clk) disable iff (rst)
    idle == CW'(GAP_CYC) |-> ch_out == '0);
endmodule

bind ppm_token_decoder ppm_token_decoder_chk #(.NUM_CH(NUM_CH), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .fs_q(fs_sync[1]), .sr(sr), .ch_out(ch_out)
);

// File: tb/sim_ppm_token_decoder.sv
module sim_ppm_token_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int LAG  = 3;
  localparam int GAP  = 64;
  localparam int NCH  = 6;
  localparam int SLOT = 20;

  logic clk = 1'b0, rst = 1'b1, fs = 1'b0, pl = 1'b0;
  logic [NCH-1:0] ch;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppm_token_decoder #(.NUM_CH(NCH), .LAG_CYC(LAG), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst(rst), .frame_start_in(fs), .pulse_in(pl), .ch_out(ch));

  task automatic check(string req, logic [NCH-1:0] exp);
    checks++;
    if (ch !== exp) begin
      errors++;
      $display("FAIL %s: ch_out=%b expected %b at %0t", req, ch, exp, $time);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; fs = 1'b0; pl = 1'b0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
  endtask

  task automatic edge_slot(logic fs_on, logic fs_keep);
    pl = 1'b1; fs = fs_on;
    cycles(4);
    pl = 1'b0;
    cycles(4);
    if (!fs_keep) fs = 1'b0;
    cycles(SLOT - 8);
  endtask

  function automatic logic [NCH-1:0] expect_k(int k);
    return (k >= 1 && k <= NCH) ? NCH'(1) << (k - 1) : '0;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: ch_out=%b expected run end", ch);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(2);
    check("R1 reset state", '0);
    rst = 1'b0;
    cycles(1);

    // R2: exact latency from pulse edge to output
    do_reset();
    fs = 1'b1; pl = 1'b1;
    cycles(LAG + 2);
    check("R2 before shift edge", '0);
    cycles(1);
    check("R2 on shift edge", NCH'(1));
    fs = 1'b0; pl = 1'b0;

    // R4 / R5: sweep frames of 1..8 pulse edges
    for (int n = 1; n <= 8; n++) begin
      do_reset();
      for (int k = 1; k <= n; k++) begin
        edge_slot(k == 1, 1'b0);
        check("R5/R4 frame decode", expect_k(k));
      end
      cycles(GAP + 16);
      check("R7 idle clears", '0);
    end

    // R3: window held over two edges loads two tokens
    do_reset();
    edge_slot(1'b1, 1'b1);
    check("R3 first load", NCH'(1));
    edge_slot(1'b1, 1'b0);
    check("R3 second load", NCH'(3));
    edge_slot(1'b0, 1'b0);
    check("R3 zero loaded", NCH'(6));

    // R6: no edge -> no change
    do_reset();
    edge_slot(1'b1, 1'b0);
    fs = 1'b1; cycles(10); fs = 1'b0; cycles(2);
    check("R6 window toggle without edge", NCH'(1));
    pl = 1'b1; cycles(10);
    check("R6 held pulse one shift", NCH'(2));
    cycles(20);
    check("R6 held pulse no further shift", NCH'(2));
    pl = 1'b0; cycles(20);
    check("R6 falling edge ignored", NCH'(2));

    // R7: exact timeout boundary
    do_reset();
    edge_slot(1'b1, 1'b0);
    cycles(GAP - 15);
    check("R7 token kept before timeout", NCH'(1));
    cycles(1);
    check("R7 token cleared at timeout", '0);

    // R1: reset in mid-frame
    do_reset();
    edge_slot(1'b1, 1'b0);
    edge_slot(1'b0, 1'b0);
    edge_slot(1'b0, 1'b0);
    check("R1 pre-reset", NCH'(4));
    rst = 1'b1; cycles(1);
    check("R1 mid-frame reset", '0);
    rst = 1'b0; cycles(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule